// File: doc/BRIEF.md
# PCI Bus Target with Selectable Termination

This block is the slave side of a PCI-style multiplexed address/data bus. When an initiator opens a cycle, the block compares the address against a base register. A single configuration write loads that register. The block takes part only in memory and I/O commands that fall inside its naturally aligned window. It claims a cycle with DEVSEL# and paces words with TRDY# against the initiator's IRDY#. Each word's window offset and data go to a flat local memory port: writes leave through it, and read data enters through it.

Simple control inputs set whether a claim answers with a retry, whether TRDY# is held back for wait states, and how a running burst ends. A burst can end with a disconnect carrying one final word, a disconnect with no further word, or a target abort. Even parity runs over AD and C/BE#. PAR is sent one clock behind each read word. The PAR the initiator sends with each write word is checked, and PERR# is raised on a mismatch.

Top module: `pci_target`

## Requirements
- R1: A cycle is claimed when an address phase (FRAME# sampled low after being high while idle) carries a command of memory read 4'b0110, memory write 4'b0111, I/O read 4'b0010 or I/O write 4'b0011 on C/BE#, and AD[31:WIN] equals the base. DEVSEL# goes low in the next clock, with TRDY# low in that same clock unless wait or retry is requested.
- R2: Before the first configuration write, and for any address outside the window or any other command, the block leaves DEVSEL#, TRDY# and STOP# high and performs no memory access.
- R3: A word moves only on a clock where IRDY# and TRDY# are both low. TRDY# stays high in every clock that follows a clock with ctlWait sampled high.
- R4: memAddr carries the address minus the base, starting from the address phase and advancing by 4 after each moved word. Writes show memWe with memWdata = AD. Reads drive memRdata onto adOut with adOe high.
- R5: With ctlRetry high at the address phase, DEVSEL# and STOP# go low with TRDY# high, and no word moves.
- R6: termSel 2'b01 (disconnect with data) drops STOP# while keeping TRDY# low. Exactly one more word moves, then TRDY# rises. DEVSEL# rises one clock after FRAME# is seen high.
- R7: termSel 2'b10 (disconnect without data) drops STOP# and raises TRDY# on the same clock, and no further word moves. DEVSEL# rises one clock after FRAME# is seen high.
- R8: termSel 2'b11 (target abort) drops STOP# and raises both DEVSEL# and TRDY# on the same clock, and no further word moves.
- R9: One clock after each read word, parOe is high and parOut makes the count of ones in {AD, C/BE#, PAR} even.
- R10: When the PAR supplied one clock after a write word breaks even parity, PERR# is low for the following clock only.
- R11: After reset and after every completed or terminated cycle, DEVSEL#, TRDY#, STOP# and PERR# are high and adOe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write strobe: loads the base and enables decode |
| cfgBase | input | 32 | Base address; bits below WIN are ignored |
| frameN | input | 1 | Initiator cycle frame, active low |
| irdyN | input | 1 | Initiator ready, active low |
| cbeN | input | 4 | Command in address phase, byte enables in data phases |
| adIn | input | 32 | Address/data from the bus |
| parIn | input | 1 | Parity from the initiator for write words |
| ctlRetry | input | 1 | Answer the next claim with a retry |
| ctlWait | input | 1 | Hold TRDY# high in the next clock |
| termSel | input | 2 | Termination request: 00 none, 01 with data, 10 without data, 11 abort |
| devselN | output | 1 | Device select, active low |
| trdyN | output | 1 | Target ready, active low |
| stopN | output | 1 | Stop request, active low |
| adOut | output | 32 | Read data to the bus |
| adOe | output | 1 | Read data drive enable |
| parOut | output | 1 | Parity for the previous read word |
| parOe | output | 1 | Parity drive enable |
| perrN | output | 1 | Data parity error, active low |
| memAddr | output | 8 | Byte offset inside the window |
| memWe | output | 1 | Local write strobe |
| memWdata | output | 32 | Local write data |
| memRdata | input | 32 | Local read data for memAddr |

## Verification
In the disconnect-with-data case, a termination request and a word transfer occur on the same clock. The request is raised while TRDY# and IRDY# are both low, so the edge that drops STOP# also moves a word. The bench then expects the word on that edge plus exactly one more, and each of these must show up at the memory port with the right offset. A second overlap is a parity error on one write word while the next word of the burst is moving. The expected PERR# pulse is tied to the word carrying bad parity through a two-clock pipeline. A scoreboard checks the memory port traffic in parallel.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_LAST = 2'd2,
    ST_HOLD = 2'd3
  } tstate_e;

  typedef enum logic [1:0] {
    TERM_NONE  = 2'b00,
    TERM_WDATA = 2'b01,
    TERM_NDATA = 2'b10,
    TERM_ABORT = 2'b11
  } term_e;

  // strobes from control to datapath
  typedef struct packed {
    logic claim;
    logic xfer;
    logic active;
  } strobe_t;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

endpackage

// File: rtl/pci_tgt_ctrl.sv
module pci_tgt_ctrl
  import pci_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       irdyN,
  input  logic       hit,
  input  logic       ctlRetry,
  input  logic       ctlWait,
  input  logic [1:0] termSel,
  output logic       devselN,
  output logic       trdyN,
  output logic       stopN,
  output strobe_t    stb
);

  tstate_e state;
  logic    prevFrameN;
  logic    inData;

  always_comb begin
    inData     = (state == ST_DATA) || (state == ST_LAST);
    stb.claim  = (state == ST_IDLE) && !frameN && prevFrameN && hit;
    stb.xfer   = inData && !irdyN && !trdyN;
    stb.active = inData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      prevFrameN <= 1'b1;
      devselN    <= 1'b1;
      trdyN      <= 1'b1;
      stopN      <= 1'b1;
    end else begin
      prevFrameN <= frameN;
      case (state)
        ST_IDLE: begin
          if (stb.claim) begin
            devselN <= 1'b0;
            if (ctlRetry) begin
              stopN <= 1'b0;
              trdyN <= 1'b1;
              state <= ST_HOLD;
            end else begin
              trdyN <= ctlWait;
              state <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (stb.xfer && frameN) begin
            devselN <= 1'b1;
            trdyN   <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            case (term_e'(termSel))
              TERM_ABORT: begin
                stopN   <= 1'b0;
                devselN <= 1'b1;
                trdyN   <= 1'b1;
                state   <= ST_HOLD;
              end
              TERM_NDATA: begin
                stopN <= 1'b0;
                trdyN <= 1'b1;
                state <= ST_HOLD;
              end
              TERM_WDATA: begin
                stopN <= 1'b0;
                trdyN <= 1'b0;
                state <= ST_LAST;
              end
              default: trdyN <= ctlWait;
            endcase
          end
        end
        ST_LAST: begin
          if (stb.xfer) begin
            trdyN <= 1'b1;
            if (frameN) begin
              devselN <= 1'b1;
              stopN   <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              state <= ST_HOLD;
            end
          end
        end
        default: begin
          if (frameN) begin
            devselN <= 1'b1;
            trdyN   <= 1'b1;
            stopN   <= 1'b1;
            state   <= ST_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/pci_tgt_dpath.sv
module pci_tgt_dpath
  import pci_tgt_pkg::*;
#(
  parameter int AW  = 32,
  parameter int WIN = 8,
  parameter int CW  = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [AW-1:0] cfgBase,
  input  logic [AW-1:0] adIn,
  input  logic [CW-1:0] cbeN,
  input  logic          parIn,
  input  strobe_t       stb,
  output logic          hit,
  output logic          cfgDone,
  output logic [AW-1:0] adOut,
  output logic          adOe,
  output logic          parOut,
  output logic          parOe,
  output logic          perrN,
  output logic [WIN-1:0] memAddr,
  output logic          memWe,
  output logic [AW-1:0] memWdata,
  input  logic [AW-1:0] memRdata
);

  localparam logic [AW-1:0]  WIN_MASK = {{(AW-WIN){1'b1}}, {WIN{1'b0}}};
  localparam logic [WIN-1:0] STEP     = WIN'(CW);

  logic [AW-1:0]  baseQ;
  logic [WIN-1:0] offQ;
  logic           isWrQ;
  logic           cmdOk;
  logic           wrPendQ;
  logic           wrSumQ;

  always_comb begin
    cmdOk = (cbeN == CMD_MEM_RD) || (cbeN == CMD_MEM_WR) ||
            (cbeN == CMD_IO_RD)  || (cbeN == CMD_IO_WR);
    hit   = cfgDone && cmdOk && ((adIn & WIN_MASK) == baseQ);
  end

  assign memAddr  = offQ;
  assign memWe    = stb.xfer && isWrQ;
  assign memWdata = adIn;
  assign adOut    = memRdata;
  assign adOe     = stb.active && !isWrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ   <= '0;
      cfgDone <= 1'b0;
      offQ    <= '0;
      isWrQ   <= 1'b0;
      parOut  <= 1'b0;
      parOe   <= 1'b0;
      wrPendQ <= 1'b0;
      wrSumQ  <= 1'b0;
      perrN   <= 1'b1;
    end else begin
      if (cfgWe) begin
        baseQ   <= cfgBase & WIN_MASK;
        cfgDone <= 1'b1;
      end
      if (stb.claim) begin
        offQ  <= adIn[WIN-1:0] - baseQ[WIN-1:0];
        isWrQ <= cbeN[0];
      end else if (stb.xfer) begin
        offQ <= offQ + STEP;
      end
      // read parity follows the word by one clock
      parOe  <= stb.xfer && !isWrQ;
      parOut <= ^{memRdata, cbeN};
      // write parity: capture word, compare with PAR next clock
      wrPendQ <= stb.xfer && isWrQ;
      wrSumQ  <= ^{adIn, cbeN};
      perrN   <= !(wrPendQ && (wrSumQ ^ parIn));
    end
  end

endmodule

// File: rtl/pci_target.sv
module pci_target
  import pci_tgt_pkg::*;
#(
  parameter int AW  = 32,
  parameter int WIN = 8,
  parameter int CW  = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgWe,
  input  logic [AW-1:0]  cfgBase,
  input  logic           frameN,
  input  logic           irdyN,
  input  logic [CW-1:0]  cbeN,
  input  logic [AW-1:0]  adIn,
  input  logic           parIn,
  input  logic           ctlRetry,
  input  logic           ctlWait,
  input  logic [1:0]     termSel,
  output logic           devselN,
  output logic           trdyN,
  output logic           stopN,
  output logic [AW-1:0]  adOut,
  output logic           adOe,
  output logic           parOut,
  output logic           parOe,
  output logic           perrN,
  output logic [WIN-1:0] memAddr,
  output logic           memWe,
  output logic [AW-1:0]  memWdata,
  input  logic [AW-1:0]  memRdata
);

  strobe_t stb;
  logic    hit;
  logic    cfgDone;

  pci_tgt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .hit(hit),
    .ctlRetry(ctlRetry), .ctlWait(ctlWait), .termSel(termSel),
    .devselN(devselN), .trdyN(trdyN), .stopN(stopN), .stb(stb)
  );

  pci_tgt_dpath #(.AW(AW), .WIN(WIN), .CW(CW)) u_dpath (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgBase(cfgBase),
    .adIn(adIn), .cbeN(cbeN), .parIn(parIn), .stb(stb),
    .hit(hit), .cfgDone(cfgDone), .adOut(adOut), .adOe(adOe),
    .parOut(parOut), .parOe(parOe), .perrN(perrN),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata)
  );

endmodule

// File: rtl/pci_target_chk.sv
module pci_target_chk (
  input logic clk,
  input logic rstN,
  input logic frameN,
  input logic irdyN,
  input logic devselN,
  input logic trdyN,
  input logic stopN,
  input logic parOe,
  input logic cfgDone
);

  // R3: a ready target must also be selected
  a_r3_trdy_with_devsel: assert property (@(posedge clk) disable iff (!rstN)
    !trdyN |-> !devselN);

  // R2: no claim before configuration
  a_r2_claim_after_cfg: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devselN) |-> cfgDone);

  // R8: stop without select means TRDY# released as well
  a_r8_abort_shape: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(stopN) && devselN) |-> trdyN);

  // R6: STOP# stays low until FRAME# is seen high
  a_r6_stop_held: assert property (@(posedge clk) disable iff (!rstN)
    (!stopN && !frameN) |=> !stopN);

  // R9: PAR drive only follows a moved word
  a_r9_par_after_word: assert property (@(posedge clk) disable iff (!rstN)
    parOe |-> $past(!trdyN && !irdyN));

endmodule

bind pci_target pci_target_chk u_chk (
  .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN),
  .devselN(devselN), .trdyN(trdyN), .stopN(stopN), .parOe(parOe),
  .cfgDone(cfgDone)
);

// File: tb/tb_pci_target.sv
module tb_pci_target;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h4000_1200;

  typedef struct {
    bit          wr;
    logic [7:0]  off;
    logic [31:0] data;
    bit          badPar;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [31:0] cfgBase = '0;
  logic        frameN = 1'b1;
  logic        irdyN = 1'b1;
  logic [3:0]  cbeN = 4'hF;
  logic [31:0] adIn = '0;
  logic        parIn = 1'b0;
  logic        ctlRetry = 1'b0;
  logic        ctlWait = 1'b0;
  logic [1:0]  termSel = 2'b00;
  logic        devselN, trdyN, stopN, adOe, parOut, parOe, perrN, memWe;
  logic [31:0] adOut, memWdata, memRdata;
  logic [7:0]  memAddr;

  logic [31:0] mem [64];
  item_t       sb[$];
  int          nChk = 0;
  int          nFail = 0;
  int          cyc = 0;
  logic [31:0] seed = 32'h1000_0000;

  // results of the last bus cycle
  bit rClaim, rSawStop, rStopDev, rStopTrdy, rDevHeld, rIdle;
  int rWait, rWords, rAtStop;

  // monitor state
  bit   perrS1 = 0, perrS2 = 0, parPend = 0;
  logic parExp = 0;

  pci_target dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgBase(cfgBase),
    .frameN(frameN), .irdyN(irdyN), .cbeN(cbeN), .adIn(adIn), .parIn(parIn),
    .ctlRetry(ctlRetry), .ctlWait(ctlWait), .termSel(termSel),
    .devselN(devselN), .trdyN(trdyN), .stopN(stopN), .adOut(adOut), .adOe(adOe),
    .parOut(parOut), .parOe(parOe), .perrN(perrN),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  assign memRdata = mem[memAddr[7:2]];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wdata(input int p);
    return seed + 32'(p) * 32'h0111_0111;
  endfunction

  // monitor: pops scoreboard items as words move
  always @(negedge clk) begin
    if (rstN) begin
      if (perrS2 || !perrN) chk("R10 perr", 32'(perrN), 32'(!perrS2));
      perrS2 = perrS1;
      perrS1 = 0;
      if (parPend) begin
        chk("R9 parOe", 32'(parOe), 32'd1);
        chk("R9 parOut", 32'(parOut), 32'(parExp));
      end
      parPend = 0;
      if (memWe && irdyN) chk("R3 write without IRDY", 32'(memWe), 32'd0);
      if (!irdyN && !trdyN) begin
        if (sb.size() == 0) begin
          chk("R4 unexpected word", 32'd1, 32'd0);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk("R4 offset", 32'(memAddr), 32'(it.off));
          if (it.wr) begin
            chk("R4 memWe", 32'(memWe), 32'd1);
            chk("R4 wdata", memWdata, it.data);
            mem[it.off[7:2]] = memWdata;
            perrS1 = it.badPar;
          end else begin
            chk("R4 adOe", 32'(adOe), 32'd1);
            chk("R4 rdata", adOut, it.data);
            parPend = 1;
            parExp  = ^{adOut, cbeN};
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nFail++;
      $display("FAIL watchdog R11: actual %0d cycles expected < 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  task automatic present(input int p, input bit wr, input logic [7:0] off0, input int badAt);
    item_t it;
    it.wr     = wr;
    it.off    = off0 + 8'(4 * p);
    it.data   = wr ? wdata(p) : mem[it.off[7:2]];
    it.badPar = wr && (p == badAt);
    sb.push_back(it);
    adIn = wr ? wdata(p) : 32'h0;
  endtask

  task automatic busCycle(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                          input bit retry, input int waitN, input int stallAt,
                          input int termAt, input logic [1:0] tm, input int badAt);
    bit   wr = cmd[0];
    int   cnt = 0, pres = 0, guard = 0, w = waitN;
    bit   stopped = 0, xfer = 0, first = 1, termSet = 0, termLive = 0, held = 0, stalled = 0;
    logic [7:0] off0 = addr[7:0] - BASE[7:0];
    rClaim = 0; rSawStop = 0; rStopDev = 1; rStopTrdy = 1; rDevHeld = 0;
    rIdle = 0; rWait = 0; rWords = 0; rAtStop = -1;
    frameN = 0; adIn = addr; cbeN = cmd; irdyN = 1;
    ctlRetry = retry; ctlWait = (w > 0);
    @(posedge clk); #1;
    ctlRetry = 0;
    w--; ctlWait = (w > 0);
    cbeN = 4'h0; frameN = (n == 1);
    present(0, wr, off0, badAt); pres = 1;
    if (stallAt == 0) begin irdyN = 1; stalled = 1; end else irdyN = 0;
    if (tm != 2'b00 && termAt == 0) begin termSel = tm; termSet = 1; termLive = 1; end
    forever begin
      @(negedge clk);
      xfer = !irdyN && !trdyN;
      if (first) begin rClaim = !devselN; first = 0; end
      if (!devselN && trdyN && stopN) rWait++;
      if (!stopN && !rSawStop) begin
        rSawStop = 1; rStopDev = devselN; rStopTrdy = trdyN; rAtStop = cnt;
      end
      if (stopped && frameN && !held) begin rDevHeld = !devselN; held = 1; end
      guard++;
      @(posedge clk); #1;
      parIn = 0;
      if (xfer) begin
        cnt++;
        if (wr) parIn = (^wdata(cnt-1)) ^ (cnt-1 == badAt);
      end
      if (termLive) begin termSel = 2'b00; termLive = 0; end
      w--; ctlWait = (w > 0);
      stopped = rSawStop || (!rClaim && guard >= 3) || guard > 40;
      if (frameN && (xfer || stopped)) break;
      if (stopped) begin
        frameN = 1;
        irdyN  = 0;
      end else if (stalled) begin
        irdyN = 0; stalled = 0;
      end else if (xfer) begin
        if (tm != 2'b00 && !termSet && cnt == termAt) begin
          termSel = tm; termSet = 1; termLive = 1;
        end
        if (pres < n) begin
          present(pres, wr, off0, badAt); pres++;
          frameN = (pres == n);
          if (pres - 1 == stallAt) begin irdyN = 1; stalled = 1; end
        end
      end
    end
    irdyN = 1; frameN = 1; termSel = 2'b00; ctlWait = 0; cbeN = 4'hF;
    if (pres > cnt) sb.pop_back();
    rWords = cnt;
    @(negedge clk);
    rIdle = devselN && trdyN && stopN && !adOe;
    @(posedge clk); #1;
    parIn = 0;
    seed = seed + 32'h0F0F_0001;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 + 32'(i);
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    chk("R11 reset outputs", {26'd0, devselN, trdyN, stopN, perrN, adOe, parOe}, 32'b111100);

    // R2: unconfigured target ignores a memory write
    @(posedge clk); #1;
    busCycle(4'b0111, BASE + 32'h10, 1, 0, 0, -1, -1, 2'b00, -1);
    chk("R2 no claim unconfigured", 32'(rClaim), 32'd0);
    chk("R2 no words unconfigured", 32'(rWords), 32'd0);

    cfgBase = BASE | 32'h55; cfgWe = 1;
    @(posedge clk); #1 cfgWe = 0;

    // R1, R3, R4: memory write burst with two wait clocks
    busCycle(4'b0111, BASE + 32'h20, 4, 0, 2, -1, -1, 2'b00, -1);
    chk("R1 claim mem write", 32'(rClaim), 32'd1);
    chk("R3 wait clocks", 32'(rWait), 32'd2);
    chk("R4 burst words", 32'(rWords), 32'd4);
    chk("R11 idle after burst", 32'(rIdle), 32'd1);

    // R1, R3, R9: read back with an IRDY# stall on word 2
    busCycle(4'b0110, BASE + 32'h20, 4, 0, 0, 2, -1, 2'b00, -1);
    chk("R1 claim mem read", 32'(rClaim), 32'd1);
    chk("R3 read words with stall", 32'(rWords), 32'd4);

    // R1: I/O write then I/O read
    busCycle(4'b0011, BASE + 32'h40, 1, 0, 0, -1, -1, 2'b00, -1);
    chk("R1 claim io write", 32'(rClaim), 32'd1);
    busCycle(4'b0010, BASE + 32'h40, 1, 0, 0, -1, -1, 2'b00, -1);
    chk("R1 io read words", 32'(rWords), 32'd1);

    // R2: outside window, and unsupported command inside it
    busCycle(4'b0111, BASE + 32'h100, 2, 0, 0, -1, -1, 2'b00, -1);
    chk("R2 miss window", 32'(rClaim), 32'd0);
    busCycle(4'b1010, BASE + 32'h08, 1, 0, 0, -1, -1, 2'b00, -1);
    chk("R2 other command", 32'(rClaim), 32'd0);

    // R5: retry
    busCycle(4'b0111, BASE + 32'h30, 2, 1, 0, -1, -1, 2'b00, -1);
    chk("R5 retry devsel low", 32'(rStopDev), 32'd0);
    chk("R5 retry trdy high", 32'(rStopTrdy), 32'd1);
    chk("R5 retry no words", 32'(rWords), 32'd0);
    chk("R11 idle after retry", 32'(rIdle), 32'd1);

    // R6: disconnect with data, request after one word
    busCycle(4'b0111, BASE + 32'h60, 6, 0, 0, -1, 1, 2'b01, -1);
    chk("R6 trdy low with stop", 32'(rStopTrdy), 32'd0);
    chk("R6 words at stop", 32'(rAtStop), 32'd2);
    chk("R6 one more word", 32'(rWords - rAtStop), 32'd1);
    chk("R6 devsel held", 32'(rDevHeld), 32'd1);
    chk("R11 idle after R6", 32'(rIdle), 32'd1);

    // R7: disconnect without data, request after two words
    busCycle(4'b0111, BASE + 32'h80, 6, 0, 0, -1, 2, 2'b10, -1);
    chk("R7 trdy high with stop", 32'(rStopTrdy), 32'd1);
    chk("R7 devsel low with stop", 32'(rStopDev), 32'd0);
    chk("R7 no further word", 32'(rWords - rAtStop), 32'd0);
    chk("R7 words total", 32'(rWords), 32'd3);
    chk("R7 devsel held", 32'(rDevHeld), 32'd1);

    // R8: target abort on a read
    busCycle(4'b0110, BASE + 32'h60, 5, 0, 0, -1, 0, 2'b11, -1);
    chk("R8 devsel high with stop", 32'(rStopDev), 32'd1);
    chk("R8 trdy high with stop", 32'(rStopTrdy), 32'd1);
    chk("R8 words total", 32'(rWords), 32'd1);
    chk("R11 idle after abort", 32'(rIdle), 32'd1);

    // R10: bad parity on word 1 of a write burst
    busCycle(4'b0111, BASE + 32'hA0, 3, 0, 0, -1, -1, 2'b00, 1);
    chk("R10 words", 32'(rWords), 32'd3);
    repeat (3) @(negedge clk);
    chk("R10 perr released", 32'(perrN), 32'd1);
    chk("R4 scoreboard drained", 32'(sb.size()), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule